// File: doc/BRIEF.md
# Transmit Timestamp Corrector for Marker-Interrupted Block Streams

This block sits in a transmit coding path that moves one 257-bit transcoded block per clock. Each 257-bit block holds four 64-bit slots, and any one of them may carry the start control block of a frame. The block notes which slot holds the start of each frame. It captures the free-running time-of-day value at the cycle that block is accepted. It then works out the time at which the first symbol after the start-of-frame delimiter would reach the line if marker groups and rate-matching idles had been inserted ahead of the MAC-side interface.

The block also schedules the marker groups itself. After a programmable number of accepted blocks, it raises a stall for four block times in the narrow mode or eight block times in the wide mode. While a frame's timestamp is pending, it accumulates idle insertion and deletion pulses. When the block that follows the start block is accepted, it emits one corrected timestamp. The timestamp is tagged with a frame sequence number.

Top module: `am_ts_corrector`

## Requirements
- R1: `blk_start[i]` set means slot i of the offered block holds a start block. When more than one bit is set, the lowest set index is the frame's start slot.
- R2: The reference point lies a fixed number of bit times after the start of the block that carries the start slot: 65 for slot 0, 129 for slot 1, 193 for slot 2 and 258 for slot 3.
- R3: The release block is the next block accepted after the start block. One cycle after the release block is accepted, `ts_vld` pulses for one cycle. At the same time `ts_val` equals the `tod_in` value of the start block's accept cycle plus (total bit count × `bit_inc`), modulo 2^64. The total bit count is the sum of the R2, R5 and R6 terms.
- R4: After every `am_period` accepted blocks, `am_stall` goes high on the next cycle for exactly 4 cycles (`mode_wide`=0) or 8 cycles (`mode_wide`=1). A block offered while `am_stall` is high is not accepted, and `am_stall` never rises without such a wrap. `am_period`=0 disables marker groups.
- R5: 1028 bit times (`mode_wide`=0) or 2056 bit times (`mode_wide`=1) are added when the start is in slot 3 and a marker group falls between the start block and the release block. Nothing is added for slots 0 to 2.
- R6: Each `idle_evt` pulse in a cycle where a timestamp is pending adds 257 bit times when `idle_del`=0 (insertion) and subtracts 257 bit times when `idle_del`=1 (deletion). The pending window runs from the cycle after the start block's accept cycle up to and including the release block's accept cycle. Pulses outside this window, including the start block's own cycle, have no effect.
- R7: `ts_seq` carries the sequence number of the frame being reported. Numbers start at 0 after reset and rise by one for each captured frame.
- R8: A start block accepted while a timestamp is pending is not captured and does not advance the sequence. It sets `ovl_err`, which stays high until reset.
- R9: After reset `ts_vld`, `am_stall` and `ovl_err` are 0 and `ts_seq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tod_in | input | 64 | Time of day, ns with 16 fractional bits |
| bit_inc | input | 24 | Duration of one bit time, same format |
| am_period | input | 16 | Accepted blocks between marker groups, 0 disables |
| mode_wide | input | 1 | 1: 8-block marker group, 0: 4-block group |
| blk_vld | input | 1 | A 257-bit block is offered |
| blk_start | input | 4 | Per-slot start-block flags of the offered block |
| idle_evt | input | 1 | Idle insertion or deletion pulse |
| idle_del | input | 1 | 1: the pulse is a deletion, 0: an insertion |
| am_stall | output | 1 | Marker group in progress, upstream must hold |
| ts_vld | output | 1 | Corrected timestamp valid |
| ts_val | output | 64 | Corrected timestamp |
| ts_seq | output | 8 | Sequence number of the reported frame |
| ovl_err | output | 1 | Sticky overlapping-start error |

## Verification
The bench sweeps both group sizes against all four start slots. For each slot it places the start block either on the block that completes a marker period or away from it, which separates the slot-3-only marker term from the plain slot offset. Three idle patterns are crossed with each case: none, two insertions inside the window, and three deletions plus an insertion on the release cycle itself. Each also carries a pulse in the start block's own cycle, which exposes errors in where the pending window begins and ends and in the sign of the idle term. Multi-bit start flags test the lowest-slot priority, and a start in the release block tests overlap handling. A long run with the period set to zero tests the disable case.

// File: rtl/ts_corr_pkg.sv
`timescale 1ns/1ps
package ts_corr_pkg;
  localparam int BLK_BITS   = 257;
  localparam int SLOT_BITS  = 64;
  localparam int SLOTS      = 4;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int GRP_NARROW = 4;
  localparam int GRP_WIDE   = 8;
  localparam int GRP_CNT_W  = $clog2(GRP_WIDE + 1);

  // bit times from block start to the first symbol after the delimiter
  function automatic int ref_off_bits(input int slot);
    return 1 + SLOT_BITS * (slot + 1) + ((slot == SLOTS - 1) ? 1 : 0);
  endfunction

  function automatic int grp_blocks(input logic wide);
    return wide ? GRP_WIDE : GRP_NARROW;
  endfunction

  function automatic int grp_bits(input logic wide);
    return grp_blocks(wide) * BLK_BITS;
  endfunction

  // total signed bit-time correction for one message
  function automatic int corr_bits(input int slot, input logic am_hit,
                                   input logic wide, input int idle_net);
    int t;
    t = ref_off_bits(slot) + idle_net * BLK_BITS;
    if (am_hit && slot == SLOTS - 1) t = t + grp_bits(wide);
    return t;
  endfunction
endpackage

// File: rtl/sop_detect.sv
`timescale 1ns/1ps
module sop_detect
  import ts_corr_pkg::*;
(
  input  logic [SLOTS-1:0]  start_flags,
  output logic              sop_hit,
  output logic [SLOT_W-1:0] sop_slot
);
  logic [SLOTS-1:0] grant;

  assign grant[0] = start_flags[0];
  generate
    for (genvar i = 1; i < SLOTS; i++) begin : g_pri
      assign grant[i] = start_flags[i] & ~(|start_flags[i-1:0]);
    end
  endgenerate

  always_comb begin
    sop_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (grant[i]) sop_slot = SLOT_W'(i);
    end
  end

  assign sop_hit = |start_flags;

  // R1
  grant_onehot_chk: assert final ($onehot0(grant) && ((|grant) == sop_hit));
endmodule

// File: rtl/am_sched.sv
`timescale 1ns/1ps
module am_sched
  import ts_corr_pkg::*;
#(
  parameter int AMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_acc,
  input  logic [AMP_W-1:0] am_period,
  input  logic             mode_wide,
  output logic             am_stall,
  output logic             grp_start
);
  logic [AMP_W-1:0]     blk_cnt;
  logic [GRP_CNT_W-1:0] stall_cnt;

  assign grp_start = blk_acc && (am_period != '0) &&
                     (blk_cnt >= am_period - 1'b1);
  assign am_stall  = (stall_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_cnt   <= '0;
      stall_cnt <= '0;
    end else begin
      if (grp_start) begin
        blk_cnt   <= '0;
        stall_cnt <= GRP_CNT_W'(grp_blocks(mode_wide));
      end else begin
        if (blk_acc) blk_cnt <= blk_cnt + 1'b1;
        if (stall_cnt != '0) stall_cnt <= stall_cnt - 1'b1;
      end
    end
  end

  // checker-side run length of the stall
  logic [GRP_CNT_W-1:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= am_stall ? run_len + 1'b1 : '0;
  end

  // R4
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!am_stall && $past(am_stall)) |->
      (int'(run_len) == grp_blocks($past(mode_wide))));

  // R4
  no_accept_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(am_stall) |-> $past(grp_start));
endmodule

// File: rtl/ts_track.sv
`timescale 1ns/1ps
module ts_track
  import ts_corr_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int INC_W  = 24,
  parameter int SEQ_W  = 8,
  parameter int IDLE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_acc,
  input  logic              sop_hit,
  input  logic [SLOT_W-1:0] sop_slot,
  input  logic              am_stall,
  input  logic              mode_wide,
  input  logic [TS_W-1:0]   tod_in,
  input  logic [INC_W-1:0]  bit_inc,
  input  logic              idle_evt,
  input  logic              idle_del,
  output logic              ts_vld,
  output logic [TS_W-1:0]   ts_val,
  output logic [SEQ_W-1:0]  ts_seq,
  output logic              ovl_err
);
  logic                     pending;
  logic [TS_W-1:0]          cap_tod;
  logic [SLOT_W-1:0]        cap_slot;
  logic [SEQ_W-1:0]         cap_seq;
  logic [SEQ_W-1:0]         seq_cnt;
  logic                     am_seen;
  logic signed [IDLE_W-1:0] idle_acc;

  logic                     cap_evt, ovl_evt, rel_evt;
  logic signed [IDLE_W-1:0] idle_step, idle_next;
  int                       tot_bits;
  logic signed [TS_W-1:0]   corr_ext, inc_ext, corr_time;
  logic [TS_W-1:0]          ts_next;

  assign cap_evt = blk_acc && sop_hit && !pending;
  assign ovl_evt = blk_acc && sop_hit && pending;
  assign rel_evt = blk_acc && pending;

  assign idle_step = !idle_evt ? '0 : (idle_del ? -IDLE_W'(1) : IDLE_W'(1));
  assign idle_next = idle_acc + idle_step;

  always_comb begin
    tot_bits  = corr_bits(int'(cap_slot), am_seen, mode_wide, int'(idle_next));
    corr_ext  = TS_W'(tot_bits);
    inc_ext   = signed'({{(TS_W-INC_W){1'b0}}, bit_inc});
    corr_time = corr_ext * inc_ext;
    ts_next   = cap_tod + $unsigned(corr_time);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      cap_tod  <= '0;
      cap_slot <= '0;
      cap_seq  <= '0;
      seq_cnt  <= '0;
      am_seen  <= 1'b0;
      idle_acc <= '0;
      ts_vld   <= 1'b0;
      ts_val   <= '0;
      ts_seq   <= '0;
      ovl_err  <= 1'b0;
    end else begin
      ts_vld <= rel_evt;
      if (rel_evt) begin
        ts_val <= ts_next;
        ts_seq <= cap_seq;
      end
      if (cap_evt) begin
        pending  <= 1'b1;
        cap_tod  <= tod_in;
        cap_slot <= sop_slot;
        cap_seq  <= seq_cnt;
        seq_cnt  <= seq_cnt + 1'b1;
        am_seen  <= 1'b0;
        idle_acc <= '0;
      end else if (pending) begin
        idle_acc <= idle_next;
        if (am_stall) am_seen <= 1'b1;
        if (rel_evt)  pending <= 1'b0;
      end
      if (ovl_evt) ovl_err <= 1'b1;
    end
  end

  // R3
  out_after_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_vld |-> $past(pending));

  // R8
  ovl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_err |=> ovl_err);

  // R8
  no_capture_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_acc && sop_hit && pending) |=> (seq_cnt == $past(seq_cnt)));

  // R7
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (seq_cnt == $past(seq_cnt) + 1'b1) && pending);
endmodule

// File: rtl/am_ts_corrector.sv
`timescale 1ns/1ps
module am_ts_corrector
  import ts_corr_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int INC_W  = 24,
  parameter int AMP_W  = 16,
  parameter int SEQ_W  = 8,
  parameter int IDLE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  tod_in,
  input  logic [INC_W-1:0] bit_inc,
  input  logic [AMP_W-1:0] am_period,
  input  logic             mode_wide,
  input  logic             blk_vld,
  input  logic [SLOTS-1:0] blk_start,
  input  logic             idle_evt,
  input  logic             idle_del,
  output logic             am_stall,
  output logic             ts_vld,
  output logic [TS_W-1:0]  ts_val,
  output logic [SEQ_W-1:0] ts_seq,
  output logic             ovl_err
);
  logic              blk_acc;
  logic              grp_start;
  logic              sop_hit;
  logic [SLOT_W-1:0] sop_slot;

  assign blk_acc = blk_vld && !am_stall;

  sop_detect u_sop (
    .start_flags (blk_start),
    .sop_hit     (sop_hit),
    .sop_slot    (sop_slot)
  );

  am_sched #(.AMP_W(AMP_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_acc   (blk_acc),
    .am_period (am_period),
    .mode_wide (mode_wide),
    .am_stall  (am_stall),
    .grp_start (grp_start)
  );

  ts_track #(
    .TS_W(TS_W), .INC_W(INC_W), .SEQ_W(SEQ_W), .IDLE_W(IDLE_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_acc   (blk_acc),
    .sop_hit   (sop_hit),
    .sop_slot  (sop_slot),
    .am_stall  (am_stall),
    .mode_wide (mode_wide),
    .tod_in    (tod_in),
    .bit_inc   (bit_inc),
    .idle_evt  (idle_evt),
    .idle_del  (idle_del),
    .ts_vld    (ts_vld),
    .ts_val    (ts_val),
    .ts_seq    (ts_seq),
    .ovl_err   (ovl_err)
  );

  // R4
  grp_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_start |-> (blk_vld && !am_stall));
endmodule

// File: tb/am_ts_corrector_tb.sv
`timescale 1ns/1ps
module am_ts_corrector_tb;
  localparam logic [63:0] STEP = 64'd327680;
  localparam logic [23:0] INC  = 24'd328;
  localparam int          PER  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tod_in = 64'h0000_1234_0000_0000;
  logic [23:0] bit_inc = INC;
  logic [15:0] am_period = 16'(PER);
  logic        mode_wide = 1'b0;
  logic        blk_vld = 1'b0;
  logic [3:0]  blk_start = '0;
  logic        idle_evt = 1'b0;
  logic        idle_del = 1'b0;
  logic        am_stall, ts_vld, ovl_err;
  logic [63:0] ts_val;
  logic [7:0]  ts_seq;

  am_ts_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .tod_in(tod_in), .bit_inc(bit_inc),
    .am_period(am_period), .mode_wide(mode_wide), .blk_vld(blk_vld),
    .blk_start(blk_start), .idle_evt(idle_evt), .idle_del(idle_del),
    .am_stall(am_stall), .ts_vld(ts_vld), .ts_val(ts_val),
    .ts_seq(ts_seq), .ovl_err(ovl_err)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int          bc = 0;
  int          per_m = PER;
  bit          wrapped = 1'b0;
  bit          wrap_pend = 1'b0;
  int          wrap_len = 0;
  int          stall_run = 0;
  logic [63:0] last_tod;
  logic [7:0]  exp_seq = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_gap(input bit ie, input bit idel);
    @(negedge clk);
    if (am_stall) stall_run++;
    tod_in    = tod_in + STEP;
    blk_vld   = 1'b0;
    blk_start = '0;
    idle_evt  = ie;
    idle_del  = idel;
  endtask

  task automatic put_block(input logic [3:0] st, input bit ie, input bit idel);
    bit acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      tod_in = tod_in + STEP;
      if (am_stall) begin
        stall_run++;
        blk_vld = 1'b0; blk_start = '0; idle_evt = 1'b0; idle_del = 1'b0;
      end else begin
        acc = 1'b1;
        // R4: stall length matches the group size, or no stall at all
        chk("R4 stall run", 64'(stall_run), wrap_pend ? 64'(wrap_len) : 64'd0);
        stall_run = 0;
        wrap_pend = 1'b0;
        blk_vld = 1'b1; blk_start = st; idle_evt = ie; idle_del = idel;
        last_tod = tod_in;
        bc++;
        wrapped = 1'b0;
        if (per_m != 0 && bc >= per_m) begin
          bc = 0; wrapped = 1'b1; wrap_pend = 1'b1;
          wrap_len = mode_wide ? 8 : 4;
        end
      end
    end
  endtask

  function automatic int ref_bits(input int s);
    case (s)
      0: return 65;
      1: return 129;
      2: return 193;
      default: return 258;
    endcase
  endfunction

  function automatic logic [63:0] expect_ts(input logic [63:0] tcap, input int s,
                                            input bit am, input bit wide, input int net);
    longint b;
    b = longint'(ref_bits(s)) + longint'(net) * 257;
    if (am && s == 3) b = b + (wide ? 2056 : 1028);
    return tcap + 64'(b * longint'(INC));
  endfunction

  // one frame: start flags, expected slot, marker wanted, idle pattern
  task automatic run_frame(input logic [3:0] st, input int s, input bit want_am,
                           input int pat, input string tag);
    logic [63:0] tcap;
    bit          amh;
    int          net = 0;
    bit          relp = 1'b0;
    if (want_am) begin
      while (bc != per_m - 1) put_block(4'b0000, 1'b0, 1'b0);
    end else if (bc == per_m - 1) begin
      put_block(4'b0000, 1'b0, 1'b0);
    end
    put_block(st, 1'b1, 1'b0);            // R6: pulse in capture cycle ignored
    tcap = last_tod;
    amh  = wrapped;
    case (pat)
      1: begin put_gap(1'b1, 1'b0); put_gap(1'b1, 1'b0); net = 2; end
      2: begin
           put_gap(1'b1, 1'b1); put_gap(1'b1, 1'b1); put_gap(1'b1, 1'b1);
           relp = 1'b1; net = -2;
         end
      default: ;
    endcase
    put_gap(1'b0, 1'b0);
    chk({tag, " R3 no early ts_vld"}, 64'(ts_vld), 64'd0);
    put_block(4'b0000, relp, 1'b0);       // release block
    put_gap(1'b0, 1'b0);
    chk({tag, " R3 ts_vld"}, 64'(ts_vld), 64'd1);
    chk({tag, " R2 R5 R6 ts_val"}, ts_val, expect_ts(tcap, s, amh, mode_wide, net));
    chk({tag, " R7 ts_seq"}, 64'(ts_seq), 64'(exp_seq));
    exp_seq = exp_seq + 8'd1;
    put_gap(1'b0, 1'b0);
    chk({tag, " R3 single pulse"}, 64'(ts_vld), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk("R9 ts_vld", 64'(ts_vld), 64'd0);
    chk("R9 am_stall", 64'(am_stall), 64'd0);
    chk("R9 ovl_err", 64'(ovl_err), 64'd0);
    chk("R9 ts_seq", 64'(ts_seq), 64'd0);

    for (int m = 0; m < 2; m++) begin
      while (am_stall) put_gap(1'b0, 1'b0);
      mode_wide = m[0];
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 2; a++)
          for (int p = 0; p < 3; p++)
            run_frame(4'b0001 << s, s, a[0], p, $sformatf("m%0d s%0d am%0d p%0d", m, s, a, p));
    end

    // R1: lowest set slot wins
    run_frame(4'b1010, 1, 1'b1, 0, "R1 flags 1010");
    run_frame(4'b1000, 3, 1'b1, 1, "R1 flags 1000");
    run_frame(4'b1111, 0, 1'b1, 2, "R1 flags 1111");
    chk("R8 no overlap yet", 64'(ovl_err), 64'd0);

    // R8: start in the release block is an overlap
    begin
      logic [63:0] tcap;
      if (bc == per_m - 1) put_block(4'b0000, 1'b0, 1'b0);
      put_block(4'b0001, 1'b0, 1'b0);
      tcap = last_tod;
      put_gap(1'b0, 1'b0);
      put_block(4'b0100, 1'b0, 1'b0);
      put_gap(1'b0, 1'b0);
      chk("R8 ovl_err set", 64'(ovl_err), 64'd1);
      chk("R8 first frame kept", ts_val, expect_ts(tcap, 0, 1'b0, mode_wide, 0));
      chk("R8 ts_seq", 64'(ts_seq), 64'(exp_seq));
      exp_seq = exp_seq + 8'd1;
      put_gap(1'b0, 1'b0);
      chk("R8 ignored start not pending", 64'(ts_vld), 64'd0);
    end
    run_frame(4'b0010, 1, 1'b0, 1, "R8 after overlap");
    chk("R8 ovl_err sticky", 64'(ovl_err), 64'd1);

    // R4: period 0 disables marker groups
    while (am_stall) put_gap(1'b0, 1'b0);
    am_period = '0;
    per_m = 0;
    for (int i = 0; i < 20; i++) put_block(4'b0000, 1'b0, 1'b0);
    put_gap(1'b0, 1'b0);
    chk("R4 disabled no stall", 64'(am_stall), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule